// File: doc/BRIEF.md
# Board Identity Header Parser

This block checks the 32-byte identity header that a plug-in board carries in its configuration EEPROM, as the bytes arrive. A fetch engine upstream hands over one byte per `byte_vld` strobe together with its address. The parser confirms the marker byte, keeps a running 8-bit checksum and checks that the addresses arrive in order. At the same time it captures the board identifier, the I/O direction mask and two signed offset-correction words for the data converters.

When the final byte has been taken, the block gives a one-cycle `done` pulse. It then reports any fault on separate flags for a wrong marker, a wrong checksum and a broken address order. The captured fields appear on the outputs only when the header is valid. A synchronous `start` clears the parser so that a further header can be read. A board identifier of all ones denotes an experimental receive board and is flagged on its own output.

Top module: `idhdr_parser`

## Requirements
- R1: After reset, and in the cycle after `start` is high, `done`, `hdr_ok`, `err_magic`, `err_sum`, `err_seq` and `exp_rx` are low and all field outputs read 0; the parser then expects address 0x00.
- R2: A byte accepted at address 0x00 whose value is not 0xDB sets `err_magic` in the next cycle. The flag stays set until `start`, and parsing continues up to `done`.
- R3: `board_id` takes its bits 7..0 from address 0x01 and its bits 15..8 from address 0x02.
- R4: `io_dir` takes its bits 7..0 from address 0x03 and its bits 15..8 from address 0x04; a 1 marks a pin that the main board drives.
- R5: `ofs0` is built from 0x05 (low byte) and 0x06 (high byte), and `ofs1` from 0x07 (low byte) and 0x08 (high byte), as 16-bit two's-complement words.
- R6: `err_sum` rises together with `done` when the 8-bit sum of all 32 bytes (addresses 0x00 to 0x1F, reserved bytes 0x09 to 0x1E included) is not zero.
- R7: `done` is high for exactly one cycle: the cycle after the byte at address 0x1F is accepted in sequence.
- R8: `hdr_ok` rises with `done` when neither the marker nor the checksum is wrong, and holds until `start`. While `hdr_ok` is low, `board_id`, `io_dir`, `ofs0` and `ofs1` all read 0x0000.
- R9: `exp_rx` is high exactly when `hdr_ok` is high and `board_id` is 0xFFFF.
- R10: A strobed address other than the next expected one sets `err_seq` in the next cycle and aborts the parse. `err_seq` then holds, and later bytes are ignored with no `done`, until `start`.
- R11: A byte strobed in the same cycle as `start` is ignored, and so is any byte strobed after `done` and before `start`; neither changes the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Synchronous clear before a new header |
| byte_vld | input | 1 | Byte strobe |
| byte_addr | input | 5 | Address of the strobed byte |
| byte_data | input | 8 | Value of the strobed byte |
| done | output | 1 | One-cycle end-of-header pulse |
| hdr_ok | output | 1 | Header passed marker and checksum checks |
| board_id | output | 16 | Board identifier, 0 unless valid |
| io_dir | output | 16 | I/O direction mask, 0 unless valid |
| ofs0 | output | 16 | Converter 0 offset correction, 0 unless valid |
| ofs1 | output | 16 | Converter 1 offset correction, 0 unless valid |
| err_magic | output | 1 | Marker byte was wrong |
| err_sum | output | 1 | Checksum was wrong |
| err_seq | output | 1 | Address order broken, parse aborted |
| exp_rx | output | 1 | Valid header carries the experimental receive identifier |

## Verification
Each result comes one register stage after the byte that causes it. `err_magic` and `err_seq` appear in the cycle after the offending strobe. `done`, `err_sum` and `hdr_ok` appear in the cycle after the byte at 0x1F, and the gated fields and `exp_rx` follow `hdr_ok` in that same cycle. The bench drives each byte on a falling edge and samples on the next falling edge, which falls just after the accepting rising edge. It checks `done` there and checks it low one falling edge later.

// File: rtl/idhdr_pkg.sv
package idhdr_pkg;

    localparam int HDR_LEN     = 32;
    localparam int ADDR_W      = $clog2(HDR_LEN);
    localparam int BYTE_W      = 8;
    localparam int FIELD_BYTES = 8;            // addresses 1..8 carry fields
    localparam logic [BYTE_W-1:0] MAGIC  = 8'hDB;
    localparam logic [15:0]       EXP_ID = 16'hFFFF;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DONE  = 2'd1,
        ST_ABORT = 2'd2
    } pstate_t;

    typedef struct packed {
        logic [15:0]        id;
        logic [15:0]        io;
        logic signed [15:0] ofs0;
        logic signed [15:0] ofs1;
    } hdr_fields_t;

    // raw holds the byte of address k at bits [8*(k-1) +: 8]
    function automatic hdr_fields_t pack_fields(input logic [FIELD_BYTES*BYTE_W-1:0] raw);
        hdr_fields_t f;
        f.id   = {raw[15:8],  raw[7:0]};
        f.io   = {raw[31:24], raw[23:16]};
        f.ofs0 = {raw[47:40], raw[39:32]};
        f.ofs1 = {raw[63:56], raw[55:48]};
        return f;
    endfunction

endpackage

// File: rtl/idhdr_seq.sv
module idhdr_seq
    import idhdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              byte_vld,
    input  logic [ADDR_W-1:0] byte_addr,
    output logic              take,
    output logic              last,
    output logic              err_seq
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(HDR_LEN - 1);

    pstate_t           st_q;
    logic [ADDR_W-1:0] next_q;
    logic              live, bad;

    assign live = byte_vld && !start && (st_q == ST_RUN);
    assign take = live && (byte_addr == next_q);
    assign bad  = live && (byte_addr != next_q);
    assign last = take && (byte_addr == LAST_ADDR);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            st_q    <= ST_RUN;
            next_q  <= '0;
            err_seq <= 1'b0;
        end else if (bad) begin
            st_q    <= ST_ABORT;
            err_seq <= 1'b1;
        end else if (take) begin
            if (last) st_q   <= ST_DONE;
            else      next_q <= next_q + 1'b1;
        end
    end
endmodule

// File: rtl/idhdr_sum.sv
module idhdr_sum
    import idhdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              take,
    input  logic              last,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              done,
    output logic              err_magic,
    output logic              err_sum,
    output logic              hdr_ok
);
    logic [BYTE_W-1:0] acc_q, acc_nx;

    assign acc_nx = acc_q + byte_data;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            acc_q     <= '0;
            done      <= 1'b0;
            err_magic <= 1'b0;
            err_sum   <= 1'b0;
            hdr_ok    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (take) begin
                acc_q <= acc_nx;
                if (byte_addr == '0 && byte_data != MAGIC)
                    err_magic <= 1'b1;
                if (last) begin
                    done    <= 1'b1;
                    err_sum <= (acc_nx != '0);
                    hdr_ok  <= (acc_nx == '0) && !err_magic;
                end
            end
        end
    end
endmodule

// File: rtl/idhdr_cap.sv
module idhdr_cap
    import idhdr_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic                          take,
    input  logic [ADDR_W-1:0]             byte_addr,
    input  logic [BYTE_W-1:0]             byte_data,
    output logic [FIELD_BYTES*BYTE_W-1:0] raw
);
    for (genvar g = 0; g < FIELD_BYTES; g++) begin : g_byte
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst || start)
                q <= '0;
            else if (take && byte_addr == ADDR_W'(g + 1))
                q <= byte_data;
        end
        assign raw[g*BYTE_W +: BYTE_W] = q;
    end
endmodule

// File: rtl/idhdr_parser.sv
module idhdr_parser
    import idhdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              byte_vld,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              done,
    output logic              hdr_ok,
    output logic [15:0]       board_id,
    output logic [15:0]       io_dir,
    output logic [15:0]       ofs0,
    output logic [15:0]       ofs1,
    output logic              err_magic,
    output logic              err_sum,
    output logic              err_seq,
    output logic              exp_rx
);
    logic                          take, last;
    logic [FIELD_BYTES*BYTE_W-1:0] raw;
    hdr_fields_t                   f;

    idhdr_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .byte_vld(byte_vld),
        .byte_addr(byte_addr), .take(take), .last(last), .err_seq(err_seq)
    );

    idhdr_sum u_sum (
        .clk(clk), .rst(rst), .start(start), .take(take), .last(last),
        .byte_addr(byte_addr), .byte_data(byte_data), .done(done),
        .err_magic(err_magic), .err_sum(err_sum), .hdr_ok(hdr_ok)
    );

    idhdr_cap u_cap (
        .clk(clk), .rst(rst), .start(start), .take(take),
        .byte_addr(byte_addr), .byte_data(byte_data), .raw(raw)
    );

    assign f        = pack_fields(raw);
    assign board_id = hdr_ok ? f.id   : 16'h0000;
    assign io_dir   = hdr_ok ? f.io   : 16'h0000;
    assign ofs0     = hdr_ok ? f.ofs0 : 16'h0000;
    assign ofs1     = hdr_ok ? f.ofs1 : 16'h0000;
    assign exp_rx   = hdr_ok && (f.id == EXP_ID);
endmodule

// File: rtl/idhdr_parser_chk.sv
module idhdr_parser_chk
    import idhdr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              byte_vld,
    input logic [ADDR_W-1:0] byte_addr,
    input logic [BYTE_W-1:0] byte_data,
    input logic              done,
    input logic              hdr_ok,
    input logic [15:0]       board_id,
    input logic [15:0]       io_dir,
    input logic [15:0]       ofs0,
    input logic [15:0]       ofs1,
    input logic              err_magic,
    input logic              err_sum,
    input logic              err_seq,
    input logic              exp_rx
);
    a_r1_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> !done && !hdr_ok && !err_magic && !err_sum && !err_seq);

    a_r2_magic_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(err_magic) |-> $past(byte_vld && byte_addr == '0 && byte_data != MAGIC));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_ok_rises_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(hdr_ok) |-> done);

    a_r8_ok_no_errors: assert property (@(posedge clk) disable iff (rst)
        hdr_ok |-> !err_magic && !err_sum);

    a_r8_fields_gated: assert property (@(posedge clk) disable iff (rst)
        !hdr_ok |-> board_id == 16'h0 && io_dir == 16'h0 && ofs0 == 16'h0 && ofs1 == 16'h0);

    a_r9_exp_id: assert property (@(posedge clk) disable iff (rst)
        exp_rx |-> hdr_ok && board_id == EXP_ID);

    a_r10_seq_sticky: assert property (@(posedge clk) disable iff (rst)
        err_seq && !start |=> err_seq);

    a_r10_no_done_abort: assert property (@(posedge clk) disable iff (rst)
        err_seq |-> !done);
endmodule

bind idhdr_parser idhdr_parser_chk u_chk (.*);

// File: tb/sim_idhdr_parser.sv
module sim_idhdr_parser;
    logic        clk = 1'b0;
    logic        rst, start, byte_vld;
    logic [4:0]  byte_addr;
    logic [7:0]  byte_data;
    logic        done, hdr_ok, err_magic, err_sum, err_seq, exp_rx;
    logic [15:0] board_id, io_dir, ofs0, ofs1;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [7:0] hb [32];

    always #2.5 clk = ~clk;

    idhdr_parser u0 (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [4:0] a, input logic [7:0] d);
        byte_vld = 1'b1; byte_addr = a; byte_data = d;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // kind: 0 good, 1 bad marker, 2 bad checksum, 3 experimental id
    task automatic build(input int kind);
        logic [7:0] s;
        for (int i = 0; i < 31; i++) hb[i] = 8'($urandom);
        hb[0] = 8'hDB;
        if (kind == 1) while (hb[0] == 8'hDB) hb[0] = 8'($urandom);
        if (kind == 3) begin hb[1] = 8'hFF; hb[2] = 8'hFF; end
        if (kind != 3 && hb[1] == 8'hFF && hb[2] == 8'hFF) hb[1] = 8'h12;
        s = 8'h00;
        for (int i = 0; i < 31; i++) s = s + hb[i];
        hb[31] = 8'h00 - s;
        if (kind == 2) hb[31] = hb[31] + 8'(1 + ($urandom % 255));
    endtask

    task automatic check_result(input int kind);
        logic ok;
        ok = (kind == 0 || kind == 3);
        chk("R7 done pulse", 16'(done), 16'h1);
        chk("R2 err_magic", 16'(err_magic), 16'(kind == 1));
        chk("R6 err_sum", 16'(err_sum), 16'(kind == 2));
        chk("R8 hdr_ok", 16'(hdr_ok), 16'(ok));
        chk("R3 board_id", board_id, ok ? {hb[2], hb[1]} : 16'h0);
        chk("R4 io_dir", io_dir, ok ? {hb[4], hb[3]} : 16'h0);
        chk("R5 ofs0", ofs0, ok ? {hb[6], hb[5]} : 16'h0);
        chk("R5 ofs1", ofs1, ok ? {hb[8], hb[7]} : 16'h0);
        chk("R9 exp_rx", 16'(exp_rx), 16'(kind == 3));
        @(negedge clk);
        chk("R7 done low after one cycle", 16'(done), 16'h0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; start = 1'b0; byte_vld = 1'b0; byte_addr = '0; byte_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset flags", {10'b0, done, hdr_ok, err_magic, err_sum, err_seq, exp_rx}, 16'h0);
        chk("R1 reset board_id", board_id, 16'h0);

        // directed: known good header
        for (int i = 0; i < 31; i++) hb[i] = 8'h00;
        hb[0] = 8'hDB; hb[1] = 8'h34; hb[2] = 8'h12; hb[3] = 8'h0F; hb[4] = 8'hA0;
        hb[5] = 8'hF6; hb[6] = 8'hFF; hb[7] = 8'h0A; hb[8] = 8'h00; hb[20] = 8'h55;
        begin
            logic [7:0] s;
            s = 8'h00;
            for (int i = 0; i < 31; i++) s = s + hb[i];
            hb[31] = 8'h00 - s;
        end
        for (int i = 0; i < 32; i++) put(5'(i), hb[i]);
        check_result(0);
        chk("R5 ofs0 negative", ofs0, 16'hFFF6);

        // R11: byte after done ignored
        put(5'd1, 8'h99);
        chk("R11 byte after done ignored", board_id, 16'h1234);

        // R1: start clears
        pulse_start();
        chk("R1 start clears ok", 16'(hdr_ok), 16'h0);
        chk("R1 start clears id", board_id, 16'h0);

        // R11: start with simultaneous byte ignored
        build(0);
        start = 1'b1; byte_vld = 1'b1; byte_addr = 5'd0; byte_data = hb[0];
        @(negedge clk);
        start = 1'b0; byte_vld = 1'b0;
        for (int i = 0; i < 32; i++) put(5'(i), hb[i]);
        chk("R11 start beats byte, no err_seq", 16'(err_seq), 16'h0);
        check_result(0);

        // R10: sequence error
        pulse_start();
        build(0);
        for (int i = 0; i < 4; i++) put(5'(i), hb[i]);
        put(5'd5, hb[5]);
        chk("R10 err_seq set", 16'(err_seq), 16'h1);
        begin
            int seen;
            seen = 0;
            for (int i = 4; i < 32; i++) begin
                put(5'(i), hb[i]);
                if (done) seen = 1;
            end
            chk("R10 no done after abort", 16'(seen), 16'h0);
        end
        chk("R10 err_seq held", 16'(err_seq), 16'h1);
        chk("R10 fields zero", board_id, 16'h0);
        pulse_start();
        chk("R1 start clears err_seq", 16'(err_seq), 16'h0);

        // R2 flag timing: visible right after byte 0
        build(1);
        put(5'd0, hb[0]);
        chk("R2 err_magic next cycle", 16'(err_magic), 16'h1);
        for (int i = 1; i < 32; i++) put(5'(i), hb[i]);
        check_result(1);

        // random mix with idle gaps
        for (int n = 0; n < 40; n++) begin
            int kind;
            kind = int'($urandom % 4);
            pulse_start();
            build(kind);
            for (int i = 0; i < 32; i++) begin
                if (i != 31 && ($urandom % 4) == 0) @(negedge clk);
                put(5'(i), hb[i]);
            end
            check_result(kind);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule